// File: doc/BRIEF.md
# Triplicated Self-Repairing Register with Voted Pin Drivers

This block is a register stage hardened against single upsets. It keeps three independent copies of a state word, one per redundancy domain. A bitwise two-out-of-three vote combines them. On every clock edge each copy is reloaded from the voted word, or from the input word when a load is requested. A bit that flips in one copy is therefore outvoted at once and overwritten at the next edge. The vote is never fed back from a copy's own old value.

The block drives one shared output word as three per-domain tri-state drivers. Each driver has its own enable for every bit, computed from its domain's bit and the bits of the other two domains. A driver switches itself off exactly where its bit disagrees with the majority. The resolved pin is modelled as the wired combination of the enabled drivers. A per-domain mismatch flag reports any cycle in which that copy differs from the vote.

Three strobes, one per domain, flip one selected bit of that copy as it is written. They let a bench demonstrate the repair. Data enters as a plain load-enabled word. The block accepts a word on every cycle, so it has no back-pressure.

Top module: `tmr_voted_reg`

## Requirements
- R1: A synchronous reset (`rst` high at an edge) clears all three copies. After that edge `voted`, `pin` and `mismatch` are all zero. Load and fault strobes at that edge have no effect.
- R2: With `load_en` high at an edge, `voted` equals the `din` of that edge from the next cycle on. This holds even if one domain's strobe is active at the same edge.
- R3: With `load_en` low at an edge and at most one strobe active, `voted` keeps its value.
- R4: A strobe `inj[d]` high at an edge flips bit `inj_bit` of copy d only. The binary index runs 0 to WIDTH-1. In the next cycle `mismatch` equals the strobe vector and `voted` is not changed by the flip.
- R5: After an edge with no strobe active, all three copies equal the vote and `mismatch` is zero. A single upset is therefore repaired one cycle after it appears.
- R6: `mismatch[d]` is high in exactly the cycles in which copy d differs from `voted` in at least one bit.
- R7: Driver d is blocked on a bit exactly when its bit differs from the majority of the three bits. The block follows the truth table 0,0,0,1,1,0,0,0 for domain 0 over (R0,R1,R2) = 000..111. With at most one domain in disagreement, `pin` equals `voted`.
- R8: Two domains upset on the same bit at the same edge invert that bit of `voted`. The refresh then spreads the wrong value to all copies, so it persists. `mismatch` flags only the remaining correct domain, and only for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load `din` into all copies at this edge |
| din | input | WIDTH | Data word to load |
| inj | input | 3 | Per-domain fault strobe, bit d targets copy d |
| inj_bit | input | $clog2(WIDTH) | Index of the bit flipped by the strobes |
| voted | output | WIDTH | Bitwise majority of the three copies |
| mismatch | output | 3 | Per-domain disagreement with the vote |
| pin | output | WIDTH | Resolved value of the three tri-state drivers |

## Verification
A copy that holds a wrong word shows up at the ports one cycle after the faulty write, as its `mismatch` bit. It must vanish one cycle later, because refresh comes only from the vote. A refresh path that reused a copy's own value would leave the flag high. A voter or driver-enable error shows at once as a `voted` or `pin` word that differs from the loaded data while only one domain is corrupted. A double upset gives a lasting wrong `voted` word, which confirms that the vote is truly bitwise.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NDOM = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tmr_majority.sv
module tmr_majority #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] y
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y[i] = tmr_pkg::maj3(a[i], b[i], c[i]);
  end
endmodule

// File: rtl/tmr_copy_reg.sv
module tmr_copy_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] nxt,
  input  logic [WIDTH-1:0] flip,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    q <= nxt ^ flip;
  end
endmodule

// File: rtl/tmr_domain_driver.sv
module tmr_domain_driver #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] own,
  input  logic [WIDTH-1:0] peer_a,
  input  logic [WIDTH-1:0] peer_b,
  output logic [WIDTH-1:0] blk,
  output logic [WIDTH-1:0] drv
);
  // blocked where own bit is outvoted by both peers
  assign blk = (own & ~peer_a & ~peer_b) | (~own & peer_a & peer_b);
  // wired contribution to the shared pin: driven bits only
  assign drv = own & ~blk;
endmodule

// File: rtl/tmr_voted_reg.sv
module tmr_voted_reg #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_en,
  input  logic [WIDTH-1:0]          din,
  input  logic [tmr_pkg::NDOM-1:0]  inj,
  input  logic [IDXW-1:0]           inj_bit,
  output logic [WIDTH-1:0]          voted,
  output logic [tmr_pkg::NDOM-1:0]  mismatch,
  output logic [WIDTH-1:0]          pin
);
  localparam int unsigned ND = tmr_pkg::NDOM;

  logic [WIDTH-1:0] copy_q [ND];
  logic [WIDTH-1:0] drv    [ND];
  logic [WIDTH-1:0] blk    [ND];
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] bit_mask;

  tmr_majority #(.WIDTH(WIDTH)) u_vote (
    .a(copy_q[0]), .b(copy_q[1]), .c(copy_q[2]), .y(voted)
  );

  // recovery path: every copy is rewritten from the vote or new data
  always_comb begin
    if (rst)          nxt = '0;
    else if (load_en) nxt = din;
    else              nxt = voted;
  end

  assign bit_mask = {{(WIDTH-1){1'b0}}, 1'b1} << inj_bit;

  for (genvar d = 0; d < ND; d++) begin : g_dom
    logic [WIDTH-1:0] flip;
    assign flip = (inj[d] && !rst) ? bit_mask : '0;

    tmr_copy_reg #(.WIDTH(WIDTH)) u_copy (
      .clk(clk), .nxt(nxt), .flip(flip), .q(copy_q[d])
    );

    tmr_domain_driver #(.WIDTH(WIDTH)) u_drv (
      .own(copy_q[d]),
      .peer_a(copy_q[(d + 1) % ND]),
      .peer_b(copy_q[(d + 2) % ND]),
      .blk(blk[d]),
      .drv(drv[d])
    );

    assign mismatch[d] = |(copy_q[d] ^ voted);
  end

  assign pin = drv[0] | drv[1] | drv[2];
endmodule

// File: rtl/tmr_voted_reg_chk.sv
module tmr_voted_reg_chk #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic [WIDTH-1:0] din,
  input logic [2:0]       inj,
  input logic [IDXW-1:0]  inj_bit,
  input logic [WIDTH-1:0] voted,
  input logic [2:0]       mismatch,
  input logic [WIDTH-1:0] pin
);
  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (voted == '0 && mismatch == '0 && pin == '0));

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && load_en && $countones(inj) <= 1) |=> voted == $past(din));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && !load_en && $countones(inj) <= 1) |=> $stable(voted));

  a_r4_flag_domain: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $countones(inj) == 1) |=> mismatch == $past(inj));

  a_r5_repair: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && inj == '0) |=> mismatch == '0);

  a_r7_pin_follows_vote: assert property (@(posedge clk) disable iff (rst)
    ($past(seen_edge) && $countones(mismatch) <= 1) |-> pin == voted);
endmodule

bind tmr_voted_reg tmr_voted_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tmr_voted_reg_bench.sv
module tmr_voted_reg_bench;
  localparam int unsigned W = 8;
  localparam int unsigned IW = $clog2(W);
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 8;
  // {load_en, din, expected voted}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'hA5, 8'hA5}, {1'b0, 8'h3C, 8'hA5},
    {1'b1, 8'h3C, 8'h3C}, {1'b1, 8'hFF, 8'hFF},
    {1'b0, 8'h00, 8'hFF}, {1'b1, 8'h00, 8'h00},
    {1'b1, 8'h81, 8'h81}, {1'b0, 8'h7E, 8'h81}
  };

  logic clk = 1'b0;
  logic rst, load_en;
  logic [W-1:0] din, voted, pin;
  logic [2:0] inj, mismatch;
  logic [IW-1:0] inj_bit;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_voted_reg #(.WIDTH(W)) u_tmr_voted_reg (
    .clk(clk), .rst(rst), .load_en(load_en), .din(din), .inj(inj),
    .inj_bit(inj_bit), .voted(voted), .mismatch(mismatch), .pin(pin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one edge, then settle a quarter period past it
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic idle();
    load_en = 0; inj = '0; rst = 0;
  endtask

  initial begin
    rst = 1; load_en = 1; din = 8'hFF; inj = 3'b111; inj_bit = 3'd2;
    step();
    // R1: reset clears, strobes and load ignored
    check("R1 voted", voted, 0);
    check("R1 mismatch", mismatch, 0);
    check("R1 pin", pin, 0);
    idle();

    for (int i = 0; i < NVEC; i++) begin
      load_en = VEC[i][16]; din = VEC[i][15:8];
      step();
      check(VEC[i][16] ? "R2 load" : "R3 hold", voted, VEC[i][7:0]);
      check("R7 pin", pin, VEC[i][7:0]);
      check("R6 no mismatch", mismatch, 0);
    end
    idle();

    // R4/R5: single upset in each domain, repaired next cycle
    for (int d = 0; d < 3; d++) begin
      inj = 3'b001 << d; inj_bit = IW'(d + 2);
      step();
      inj = '0;
      check("R4 voted unchanged", voted, 8'h81);
      check("R4 mismatch domain", mismatch, 3'b001 << d);
      check("R7 pin with one fault", pin, 8'h81);
      step();
      check("R5 repaired", mismatch, 0);
      check("R5 voted", voted, 8'h81);
    end

    // R2 with a same-edge upset
    load_en = 1; din = 8'h55; inj = 3'b001; inj_bit = 3'd7;
    step();
    idle();
    check("R2 load with upset", voted, 8'h55);
    check("R6 flagged", mismatch, 3'b001);
    check("R7 pin", pin, 8'h55);
    step();
    check("R5 repaired after load", mismatch, 0);

    // R8: double upset on bit 0 in domains 0 and 2
    inj = 3'b101; inj_bit = 3'd0;
    step();
    inj = '0;
    check("R8 voted inverted", voted, 8'h54);
    check("R8 remaining domain flagged", mismatch, 3'b010);
    step();
    check("R8 wrong value persists", voted, 8'h54);
    check("R8 flag clears", mismatch, 0);

    // R1 again from non-zero state
    rst = 1; load_en = 1; din = 8'hC3; inj = 3'b010;
    step();
    idle();
    check("R1 reset from data", voted, 0);
    check("R1 mismatch after reset", mismatch, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule